// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block turns a byte stream from a MAC into the two-bit transmit side of a reduced media-independent interface (RMII). Everything runs on the single 50 MHz reference clock. The upstream source brings a frame-active flag, a byte with its valid flag, and a rate select. Each byte it hands over leaves the block as four dibits, least significant pair first, on `txd_o`, with `tx_en_o` framing the transfer.

At 100 Mbps a new dibit appears on every reference-clock cycle. At 10 Mbps the clock stays at 50 MHz and each dibit is held for a fixed number of cycles (ten by default). `byte_ready_o` tells the source when a byte offered with `byte_valid_i` is taken. It is high while the line is idle and in the final cycle of each byte's last dibit. A source that keeps a byte valid therefore gets a gap-free frame. Preamble, start delimiter and checksum are not generated here; they arrive as ordinary bytes.

Top module: `rmii_tx_serializer`

## Requirements
- R1: During and straight after reset, `tx_en_o` is 0, `txd_o` is 2'b00 and `byte_ready_o` is 1.
- R2: A byte is taken at a rising edge where `byte_ready_o`, `byte_valid_i` and `frame_active_i` are all 1. In the cycle after a byte taken from idle, `tx_en_o` is 1 and `txd_o` carries bits [1:0] of that byte.
- R3: Each byte is sent as bits [1:0], then [3:2], then [5:4], then [7:6].
- R4: When `speed_100_i` is 1 at frame start, each dibit is on `txd_o` for exactly one clock cycle.
- R5: When `speed_100_i` is 0 at frame start, each dibit is held on `txd_o` for exactly SLOW_HOLD (10) cycles.
- R6: Within a frame, `byte_ready_o` is 1 only in the last cycle of a byte's final dibit. A byte taken then has its bits [1:0] on `txd_o` in the next cycle, with no idle dibit between the two bytes.
- R7: If no byte is taken at the end of a byte, `tx_en_o` drops in the next cycle. `txd_o` is 2'b00 whenever `tx_en_o` is 0, and a frame always lasts a whole number of bytes.
- R8: `speed_100_i` is sampled only while `tx_en_o` is 0. Changing it during a frame leaves the dibit timing of that frame unchanged.
- R9: `byte_valid_i` has no effect while `frame_active_i` is 0: the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_active_i | input | 1 | Source has a frame in progress |
| byte_valid_i | input | 1 | `byte_i` holds a byte to send |
| byte_i | input | 8 | Transmit byte |
| speed_100_i | input | 1 | 1 = 100 Mbps pacing, 0 = 10 Mbps pacing |
| byte_ready_o | output | 1 | A valid byte is taken at the next rising edge |
| tx_en_o | output | 1 | Transmit enable |
| txd_o | output | 2 | Transmit dibit |

## Verification
The hardest case to reach from the ports is a change of the rate select in the middle of a slow frame. The new rate must not take effect until the line has gone idle. That only shows up if the dibit hold length is measured across every cycle of the frame. The stimulus flips `speed_100_i` a few cycles into a 10 Mbps frame and checks every cycle against a ten-cycle hold. It then restores the select before the next frame and confirms that the following frame starts at the rate sampled while idle. Back-to-back bytes are driven by presenting the next byte during the final cycle of each dibit group, so every byte boundary is crossed without a gap.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  localparam int BYTE_W_DEF   = 8;
  localparam int DIBIT_W_DEF  = 2;
  localparam int SLOW_HOLD_DEF = 10;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;
endpackage

// File: rtl/rmii_tx_pacer.sv
module rmii_tx_pacer #(
  parameter int SLOW_HOLD = rmii_tx_pkg::SLOW_HOLD_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic slow_i,
  input  logic restart_i,
  output logic step_o
);
  localparam int CNT_W = (SLOW_HOLD > 1) ? $clog2(SLOW_HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOW_HOLD - 1);

  logic [CNT_W-1:0] hold_cnt;

  // A dibit slot ends on every cycle when fast, on the last hold cycle when slow
  assign step_o = run_i && (!slow_i || (hold_cnt == CNT_LAST));

  always_ff @(posedge clk) begin
    if (rst || !run_i || step_o || restart_i) begin
      hold_cnt <= '0;
    end else if (slow_i) begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rmii_tx_shifter.sv
module rmii_tx_shifter #(
  parameter int BYTE_W  = rmii_tx_pkg::BYTE_W_DEF,
  parameter int DIBIT_W = rmii_tx_pkg::DIBIT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               step_i,
  input  logic               clear_i,
  output logic [DIBIT_W-1:0] dibit_o,
  output logic               last_o
);
  localparam int SLOTS = BYTE_W / DIBIT_W;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic [DIBIT_W-1:0] dibit_q;

  assign dibit_o = dibit_q;
  assign last_o  = (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      idx     <= '0;
      dibit_q <= '0;
    end else if (load_i) begin
      shreg   <= byte_i;
      idx     <= '0;
      dibit_q <= byte_i[DIBIT_W-1:0];
    end else if (step_i) begin
      shreg   <= shreg >> DIBIT_W;
      idx     <= idx + 1'b1;
      dibit_q <= shreg[2*DIBIT_W-1:DIBIT_W];
    end else if (clear_i) begin
      shreg   <= '0;
      idx     <= '0;
      dibit_q <= '0;
    end
  end
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
  parameter int BYTE_W    = rmii_tx_pkg::BYTE_W_DEF,
  parameter int DIBIT_W   = rmii_tx_pkg::DIBIT_W_DEF,
  parameter int SLOW_HOLD = rmii_tx_pkg::SLOW_HOLD_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_active_i,
  input  logic               byte_valid_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               speed_100_i,
  output logic               byte_ready_o,
  output logic               tx_en_o,
  output logic [DIBIT_W-1:0] txd_o
);
  import rmii_tx_pkg::*;

  logic  tx_en_q;
  rate_e rate_q;
  logic  slow_q;
  logic  step;
  logic  last_slot;
  logic  boundary;
  logic  accept;
  logic  shift_in_byte;
  logic  close_frame;

  assign slow_q        = (rate_q == RATE_SLOW);
  assign boundary      = step && last_slot;
  assign byte_ready_o  = !tx_en_q || boundary;
  assign accept        = byte_ready_o && byte_valid_i && frame_active_i;
  assign shift_in_byte = step && !last_slot;
  assign close_frame   = boundary && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q <= 1'b0;
      rate_q  <= RATE_FAST;
    end else begin
      if (!tx_en_q) begin
        rate_q <= speed_100_i ? RATE_FAST : RATE_SLOW;
      end
      if (accept) begin
        tx_en_q <= 1'b1;
      end else if (boundary) begin
        tx_en_q <= 1'b0;
      end
    end
  end

  rmii_tx_pacer #(
    .SLOW_HOLD (SLOW_HOLD)
  ) u_pacer (
    .clk       (clk),
    .rst       (rst),
    .run_i     (tx_en_q),
    .slow_i    (slow_q),
    .restart_i (accept),
    .step_o    (step)
  );

  rmii_tx_shifter #(
    .BYTE_W  (BYTE_W),
    .DIBIT_W (DIBIT_W)
  ) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .byte_i  (byte_i),
    .step_i  (shift_in_byte),
    .clear_i (close_frame),
    .dibit_o (txd_o),
    .last_o  (last_slot)
  );

  assign tx_en_o = tx_en_q;
endmodule

// File: rtl/rmii_tx_serializer_chk.sv
module rmii_tx_serializer_chk #(
  parameter int BYTE_W    = 8,
  parameter int DIBIT_W   = 2,
  parameter int SLOW_HOLD = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_active_i,
  input logic               byte_valid_i,
  input logic [DIBIT_W-1:0] byte_lo,
  input logic               byte_ready_o,
  input logic               tx_en_o,
  input logic [DIBIT_W-1:0] txd_o,
  input logic               slow_q
);
  localparam int SLOTS = BYTE_W / DIBIT_W;

  int frame_cyc;
  int per_dibit;

  assign per_dibit = slow_q ? SLOW_HOLD : 1;

  always_ff @(posedge clk) begin
    if (rst || !tx_en_o) frame_cyc <= 0;
    else                 frame_cyc <= frame_cyc + 1;
  end

  // R7: idle line carries zero
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en_o |-> (txd_o == '0));

  // R2: accepted byte starts on the next cycle with its low dibit
  assert_first_dibit_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_ready_o && byte_valid_i && frame_active_i && !tx_en_o)
      |=> (tx_en_o && txd_o == $past(byte_lo)));

  // R4 / R5: dibit changes only on slot boundaries
  assert_slot_timing_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_en_o && $past(tx_en_o) && (txd_o != $past(txd_o)))
      |-> ((frame_cyc % per_dibit) == 0));

  // R7: frame length is a whole number of bytes
  assert_whole_bytes_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en_o) |-> ((frame_cyc % (per_dibit * SLOTS)) == 0));

  // R8: rate is frozen while transmitting
  assert_rate_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_en_o && $past(tx_en_o)) |-> $stable(slow_q));

  // R9: nothing starts without frame activity
  assert_no_start_R9: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_o && !frame_active_i) |=> !tx_en_o);
endmodule

bind rmii_tx_serializer rmii_tx_serializer_chk #(
  .BYTE_W    (BYTE_W),
  .DIBIT_W   (DIBIT_W),
  .SLOW_HOLD (SLOW_HOLD)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_active_i (frame_active_i),
  .byte_valid_i   (byte_valid_i),
  .byte_lo        (byte_i[DIBIT_W-1:0]),
  .byte_ready_o   (byte_ready_o),
  .tx_en_o        (tx_en_o),
  .txd_o          (txd_o),
  .slow_q         (slow_q)
);

// File: tb/rmii_tx_serializer_tb.sv
module rmii_tx_serializer_tb;
  localparam int HOLD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       frame_active_i;
  logic       byte_valid_i;
  logic [7:0] byte_i;
  logic       speed_100_i;
  logic       byte_ready_o;
  logic       tx_en_o;
  logic [1:0] txd_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rmii_tx_serializer u_dut (
    .clk            (clk),
    .rst            (rst),
    .frame_active_i (frame_active_i),
    .byte_valid_i   (byte_valid_i),
    .byte_i         (byte_i),
    .speed_100_i    (speed_100_i),
    .byte_ready_o   (byte_ready_o),
    .tx_en_o        (tx_en_o),
    .txd_o          (txd_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_clk();
    @(posedge clk);
    #1;
  endtask

  task automatic check_idle(input string req);
    check({req, " tx_en"}, int'(tx_en_o), 0);
    check({req, " txd"},   int'(txd_o), 0);
    check({req, " ready"}, int'(byte_ready_o), 1);
  endtask

  // Send n bytes as one frame; optionally flip speed mid-frame (R8)
  task automatic run_frame(input int n, input logic [7:0] b[4],
                           input bit fast, input bit flip_mid, input string tag);
    int h;
    int k;
    h = fast ? 1 : HOLD;
    k = 0;
    speed_100_i    = fast;
    frame_active_i = 1'b1;
    byte_valid_i   = 1'b1;
    byte_i         = b[0];
    check({tag, " R2 ready idle"}, int'(byte_ready_o), 1);
    for (int i = 0; i < n; i++) begin
      for (int d = 0; d < 4; d++) begin
        for (int c = 0; c < h; c++) begin
          step_clk();
          check({tag, " R2 tx_en"}, int'(tx_en_o), 1);
          check({tag, fast ? " R4/R3 dibit" : " R5/R3 dibit"},
                int'(txd_o), int'(b[i][2*d +: 2]));
          if (flip_mid && k == 2) speed_100_i = !fast;
          k++;
          if (d == 3 && c == h - 1) begin
            check({tag, " R6 ready at boundary"}, int'(byte_ready_o), 1);
            if (i + 1 < n) begin
              byte_i = b[i+1];
            end else begin
              byte_valid_i   = 1'b0;
              frame_active_i = 1'b0;
            end
          end else begin
            check({tag, " R6 ready low mid-byte"}, int'(byte_ready_o), 0);
            if (i + 1 < n) byte_i = b[i+1];
          end
        end
      end
    end
    step_clk();
    speed_100_i = fast;
    check_idle({tag, " R7 end"});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    frame_active_i = 1'b0;
    byte_valid_i = 1'b0;
    byte_i = 8'h00;
    speed_100_i = 1'b1;
    repeat (3) step_clk();
    check_idle("R1 in reset");
    rst = 1'b0;
    step_clk();
    check_idle("R1 after reset");
  endtask

  task automatic t_ignore_valid();
    frame_active_i = 1'b0;
    byte_valid_i   = 1'b1;
    byte_i         = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      step_clk();
      check("R9 tx_en", int'(tx_en_o), 0);
      check("R9 txd",   int'(txd_o), 0);
    end
    byte_valid_i = 1'b0;
  endtask

  initial begin
    logic [7:0] b[4];
    t_reset();
    b = '{8'hE4, 8'h1B, 8'hA5, 8'h3C};
    run_frame(4, b, 1'b1, 1'b0, "fast4");
    b = '{8'hD5, 8'h00, 8'hFF, 8'h96};
    run_frame(1, b, 1'b1, 1'b0, "fast1");
    run_frame(3, b, 1'b0, 1'b0, "slow3");
    b = '{8'h72, 8'h8D, 8'h00, 8'h00};
    run_frame(2, b, 1'b0, 1'b1, "slowflip R8");
    run_frame(2, b, 1'b1, 1'b1, "fastflip R8");
    t_ignore_valid();
    b = '{8'h5A, 8'hC3, 8'h00, 8'h00};
    run_frame(2, b, 1'b1, 1'b0, "after R9");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule